// File: doc/BRIEF.md
# Half-Word Column Partial Product Generator

This block forms the column sums of a wide unsigned multiplication without resolving carries. Both operands are viewed as sequences of 16-bit half-words; with the default of eight 32-bit words that is 16 half-words per operand. The block produces 31 column sums. Column k is the sum of every half-word product whose two indices add up to k. A downstream carry-resolution stage can then fold the columns into the full product by weighting column k with 2^(16k).

A bank of multiply-accumulate lanes, one per half-word, runs for as many cycles as there are half-words. Every cycle all lanes share one half-word of operand B, which the block fetches through a read port by index. Each lane picks its own half-word of operand A on a rotating schedule. Columns in the upper half finish one by one during the run and appear on a single-word stream tagged with their column number. The lower-half columns all finish together and appear on a wide flush bus one cycle after the last upper column.

A run begins on a start strobe while the block is idle. Operand A is presented as a packed bus and must stay steady for the whole run.

Top module: `halfprod_columns`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `hiValid` and `loValid` are low.
- R2: A `start` sampled while idle is accepted. Counting the accepting edge as cycle 0, `busy` is high from cycle 0 through cycle 2N (2N+1 cycles) and low again in cycle 2N+1.
- R3: In cycle m of a run (m = 0..2N−1), `bRdIdx` equals 2N−1−m. In the flush cycle (m = 2N), it is 0.
- R4: `hiValid` is high exactly in cycles m = 2..2N, one word per cycle, and `hiCol` equals 4N−m in cycle m. The upper columns therefore come out in descending order from 4N−2 down to 2N.
- R5: `hiWord` equals the sum of a[i]·b[j] over all i+j = `hiCol`. Half-word h of A sits at bits [16h+15:16h] of `opA`. Half-word 2w is the low 16 bits of 32-bit word w, and half-word 2w+1 is its high 16 bits. `bRdHalf` must return half-word `bRdIdx` of B.
- R6: `loValid` is high for exactly one cycle, at m = 2N+1. In that cycle, field w of `loWords` (bits [w·ACCW +: ACCW]) holds column w, for w = 0..2N−1.
- R7: The sum over all 4N−1 columns of column k · 2^(16k) equals the full product A·B.
- R8: A `start` pulse during a run is ignored. The busy profile, the stream timing and all column values are those of the run already in progress.
- R9: Every run starts from cleared accumulators. A run that follows another run yields only the columns of its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, accepted only while idle |
| opA | input | 2N·16 | Operand A as packed half-words, held stable during a run |
| bRdIdx | output | log2(2N) | Half-word index of operand B needed this cycle |
| bRdHalf | input | 16 | Half-word of B at `bRdIdx`, returned in the same cycle |
| busy | output | 1 | A run or its flush cycle is in progress |
| hiValid | output | 1 | An upper column is on `hiWord` |
| hiCol | output | log2(4N−1) | Column index of `hiWord` |
| hiWord | output | ACCW | Upper column sum |
| loValid | output | 1 | Lower columns are on `loWords` |
| loWords | output | 2N·ACCW | Lower column sums, field w is column w |

## Verification
The assertions take two things for granted. The first is that the requester leaves `opA` unchanged from the accepting edge to the flush. The second is that `bRdHalf` reflects the current `bRdIdx` combinationally. The assertions only constrain the timing and ordering of the strobes, tags and read index, since the values depend on those inputs. The bench keeps within these assumptions: it changes `opA` only before asserting `start`, and it models operand B as a half-word array indexed directly by `bRdIdx`. It sweeps a single all-ones half-word across every position of A, uses structured and random operand pairs, and injects stray start pulses mid-run. Every column is compared with sums computed arithmetically in the bench.

// File: rtl/halfprod_pkg.sv
package halfprod_pkg;

  // widest cycle index carried in the control word
  localparam int CYC_MAXW = 8;

  typedef struct packed {
    logic                clrAll;  // clear every accumulator (run accepted)
    logic                step;    // one multiply-accumulate cycle
    logic                emitHi;  // lane at cyc hands over its finished column
    logic                flush;   // release all remaining lanes
    logic [CYC_MAXW-1:0] cyc;     // current run cycle
  } laneCtrl_t;

endpackage

// File: rtl/halfprod_ctrl.sv
module halfprod_ctrl
  import halfprod_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic [$clog2(LANES)-1:0] bRdIdx,
  output logic                     busy,
  output laneCtrl_t                laneCtrl
);

  localparam int CW = $clog2(LANES);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} ctrlState_t;

  ctrlState_t      state;
  logic [CW-1:0]   cycCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RUN;
            cycCnt <= '0;
          end
        end
        ST_RUN: begin
          if (cycCnt == CW'(LANES - 1)) state <= ST_FLUSH;
          else                         cycCnt <= cycCnt + 1'b1;
        end
        ST_FLUSH: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    laneCtrl               = '0;
    laneCtrl.clrAll        = (state == ST_IDLE) && start;
    laneCtrl.step          = (state == ST_RUN);
    laneCtrl.emitHi        = (state == ST_RUN) && (cycCnt != '0);
    laneCtrl.flush         = (state == ST_FLUSH);
    laneCtrl.cyc[CW-1:0]   = cycCnt;
  end

  assign bRdIdx = CW'(LANES - 1) - cycCnt;
  assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/halfprod_lanes.sv
module halfprod_lanes
  import halfprod_pkg::*;
#(
  parameter int LANES = 16,
  parameter int HALFW = 16,
  parameter int ACCW  = 47,
  parameter int COLW  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  laneCtrl_t               laneCtrl,
  input  logic [LANES*HALFW-1:0]  opA,
  input  logic [HALFW-1:0]        bHalf,
  output logic                    hiValid,
  output logic [COLW-1:0]         hiCol,
  output logic [ACCW-1:0]         hiWord,
  output logic                    loValid,
  output logic [LANES*ACCW-1:0]   loWords
);

  localparam int IDXW  = $clog2(LANES);
  localparam int PRODW = 2 * HALFW;

  logic [IDXW-1:0] cycT;
  logic [ACCW-1:0] accBus [LANES];

  assign cycT = laneCtrl.cyc[IDXW-1:0];

  for (genvar x = 0; x < LANES; x++) begin : g_lane
    logic [IDXW-1:0]  aIdx;
    logic [HALFW-1:0] aSel;
    logic [PRODW-1:0] prod;
    logic [ACCW-1:0]  accQ;

    // rotating A schedule: lane x takes half-word (t - x) mod LANES
    always_comb begin
      if (int'(cycT) >= x) aIdx = IDXW'(int'(cycT) - x);
      else                 aIdx = IDXW'(int'(cycT) + LANES - x);
    end

    assign aSel = opA[aIdx*HALFW +: HALFW];
    assign prod = PRODW'(aSel) * PRODW'(bHalf);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        accQ <= '0;
      end else if (laneCtrl.clrAll) begin
        accQ <= '0;
      end else if (laneCtrl.step) begin
        if (laneCtrl.emitHi && (cycT == IDXW'(x))) accQ <= ACCW'(prod);
        else                                       accQ <= accQ + ACCW'(prod);
      end
    end

    assign accBus[x] = accQ;
  end

  // upper column stream: lane t is finished when cycle t begins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiValid <= 1'b0;
      hiCol   <= '0;
      hiWord  <= '0;
    end else begin
      hiValid <= laneCtrl.emitHi;
      if (laneCtrl.emitHi) begin
        hiCol  <= COLW'(2 * LANES - 1 - int'(cycT));
        hiWord <= accBus[cycT];
      end
    end
  end

  // lower columns: lane LANES-1-w holds column w after the last cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loValid <= 1'b0;
      loWords <= '0;
    end else begin
      loValid <= laneCtrl.flush;
      if (laneCtrl.flush) begin
        for (int w = 0; w < LANES; w++) begin
          loWords[w*ACCW +: ACCW] <= accBus[LANES-1-w];
        end
      end
    end
  end

endmodule

// File: rtl/halfprod_columns.sv
module halfprod_columns
  import halfprod_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int WORDW  = 32,
  parameter int ACCW   = 47
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [2*NWORDS*(WORDW/2)-1:0]        opA,
  output logic [$clog2(2*NWORDS)-1:0]          bRdIdx,
  input  logic [WORDW/2-1:0]                   bRdHalf,
  output logic                                 busy,
  output logic                                 hiValid,
  output logic [$clog2(4*NWORDS-1)-1:0]        hiCol,
  output logic [ACCW-1:0]                      hiWord,
  output logic                                 loValid,
  output logic [2*NWORDS*ACCW-1:0]             loWords
);

  localparam int LANES = 2 * NWORDS;
  localparam int HALFW = WORDW / 2;
  localparam int IDXW  = $clog2(LANES);
  localparam int COLW  = $clog2(4 * NWORDS - 1);

  laneCtrl_t laneCtrl;

  halfprod_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bRdIdx   (bRdIdx),
    .busy     (busy),
    .laneCtrl (laneCtrl)
  );

  halfprod_lanes #(
    .LANES (LANES),
    .HALFW (HALFW),
    .ACCW  (ACCW),
    .COLW  (COLW)
  ) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .laneCtrl (laneCtrl),
    .opA      (opA),
    .bHalf    (bRdHalf),
    .hiValid  (hiValid),
    .hiCol    (hiCol),
    .hiWord   (hiWord),
    .loValid  (loValid),
    .loWords  (loWords)
  );

endmodule

// File: rtl/halfprod_columns_chk.sv
module halfprod_columns_chk #(
  parameter int LANES = 16,
  parameter int IDXW  = 4,
  parameter int COLW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [IDXW-1:0] bRdIdx,
  input logic            hiValid,
  input logic [COLW-1:0] hiCol,
  input logic            loValid
);

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && bRdIdx == IDXW'(LANES - 1)));

  p_idle_after_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loValid |-> !busy);

  p_bidx_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(bRdIdx) != '0) |-> bRdIdx == IDXW'($past(bRdIdx) - 1'b1));

  p_hi_first_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hiValid && !$past(hiValid)) |-> hiCol == COLW'(2 * LANES - 2));

  p_hi_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hiValid && $past(hiValid)) |-> hiCol == COLW'($past(hiCol) - 1'b1));

  p_hi_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hiValid |-> busy);

  p_lo_follows_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loValid |-> ($past(hiValid) && $past(hiCol) == COLW'(LANES)));

  p_lo_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loValid |=> !loValid);

endmodule

bind halfprod_columns halfprod_columns_chk #(
  .LANES (LANES),
  .IDXW  (IDXW),
  .COLW  (COLW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .bRdIdx  (bRdIdx),
  .hiValid (hiValid),
  .hiCol   (hiCol),
  .loValid (loValid)
);

// File: tb/halfprod_columns_bench.sv
module halfprod_columns_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NW    = 8;
  localparam int LN    = 2 * NW;
  localparam int HW    = 16;
  localparam int AW    = 47;
  localparam int NCOL  = 4 * NW - 1;
  localparam int OPW   = LN * HW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [OPW-1:0]       opA = '0;
  logic [3:0]           bRdIdx;
  logic [HW-1:0]        bRdHalf;
  logic                 busy, hiValid, loValid;
  logic [4:0]           hiCol;
  logic [AW-1:0]        hiWord;
  logic [LN*AW-1:0]     loWords;

  logic [HW-1:0] aH [LN];
  logic [HW-1:0] bH [LN];
  logic [63:0]   gotCol [NCOL];

  int checks = 0;
  int errors = 0;
  int runIdx = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bRdHalf = bH[bRdIdx];

  halfprod_columns u_halfprod_columns (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA),
    .bRdIdx(bRdIdx), .bRdHalf(bRdHalf), .busy(busy),
    .hiValid(hiValid), .hiCol(hiCol), .hiWord(hiWord),
    .loValid(loValid), .loWords(loWords)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [575:0] act, input logic [575:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] colExp(input int c);
    logic [63:0] s = '0;
    for (int i = 0; i < LN; i++) begin
      int j = c - i;
      if (j >= 0 && j < LN) s += 64'(aH[i]) * 64'(bH[j]);
    end
    return s;
  endfunction

  // one run: m counts cycles from the accepting edge (m = 0)
  task automatic runOne(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit stray);
    logic [575:0] wsum;
    logic [511:0] full;
    for (int h = 0; h < LN; h++) begin
      aH[h] = a[h*HW +: HW];
      bH[h] = b[h*HW +: HW];
    end
    for (int c = 0; c < NCOL; c++) gotCol[c] = '1;
    opA   = a;
    start = 1'b1;
    for (int m = 0; m <= LN + 1; m++) begin
      @(negedge clk);
      if (m == 0) start = 1'b0;
      if (stray && m == 4) start = 1'b1;
      if (stray && m == 5) start = 1'b0;
      // R2 / R8: busy profile
      check(busy == (m <= LN), stray ? "R8" : "R2", $sformatf("busy m=%0d", m),
            576'(busy), 576'(m <= LN));
      // R3: B read index
      if (m <= LN) begin
        int ei = (m < LN) ? (LN - 1 - m) : 0;
        check(bRdIdx == 4'(ei), "R3", $sformatf("bRdIdx m=%0d", m), 576'(bRdIdx), 576'(ei));
      end
      // R4: upper stream timing and tag
      check(hiValid == (m >= 2 && m <= LN), "R4", $sformatf("hiValid m=%0d", m),
            576'(hiValid), 576'(m >= 2 && m <= LN));
      if (hiValid && m >= 2 && m <= LN) begin
        check(int'(hiCol) == 4 * NW - m, "R4", $sformatf("hiCol m=%0d", m),
              576'(hiCol), 576'(4 * NW - m));
        gotCol[hiCol] = 64'(hiWord);
        // R5: column value
        check(64'(hiWord) == colExp(int'(hiCol)), "R5", $sformatf("hiWord col=%0d", hiCol),
              576'(hiWord), 576'(colExp(int'(hiCol))));
      end
      // R6: lower flush
      check(loValid == (m == LN + 1), "R6", $sformatf("loValid m=%0d", m),
            576'(loValid), 576'(m == LN + 1));
      if (m == LN + 1) begin
        for (int w = 0; w < LN; w++) begin
          gotCol[w] = 64'(loWords[w*AW +: AW]);
          check(gotCol[w] == colExp(w), "R6", $sformatf("loWords col=%0d", w),
                576'(gotCol[w]), 576'(colExp(w)));
        end
      end
    end
    // R7: weighted column sum equals the product
    wsum = '0;
    for (int c = 0; c < NCOL; c++) wsum += 576'(gotCol[c]) << (HW * c);
    full = 512'(a) * 512'(b);
    check(wsum == 576'(full), "R7", "weighted sum", wsum, 576'(full));
    // R9: a run after another run carries nothing over
    if (runIdx > 0) check(wsum == 576'(full), "R9", "run after run", wsum, 576'(full));
    runIdx++;
  endtask

  function automatic logic [OPW-1:0] rnd256();
    logic [OPW-1:0] v;
    for (int k = 0; k < OPW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    for (int h = 0; h < LN; h++) bH[h] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !hiValid && !loValid, "R1", "outputs in reset",
          576'({busy, hiValid, loValid}), 576'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !hiValid && !loValid, "R1", "outputs after reset",
          576'({busy, hiValid, loValid}), 576'(0));

    runOne('1, '1, 1'b0);
    runOne('0, '0, 1'b0);
    runOne(OPW'(1), OPW'(1), 1'b0);
    runOne({LN{16'haaaa}}, {LN{16'h5555}}, 1'b1);
    // sweep a single all-ones half-word of A over every position
    for (int h = 0; h < LN; h++) begin
      runOne(OPW'(16'hffff) << (HW * h), '1, (h % 5) == 2);
    end
    runOne('1, OPW'(16'hffff) << (HW * (LN - 1)), 1'b0);
    for (int r = 0; r < 10; r++) runOne(rnd256(), rnd256(), (r % 3) == 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule